// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block is a transmit-only asynchronous serial peripheral that a processor drives through a small byte-wide register interface. A single select input chooses between the data port and the control port. The control port is shared. The first control write after reset, or after a soft-reset command, is taken as a mode byte. Every later control write is a command byte. Reads at the control address return a status byte whose bit 0 tells software when another data byte may be written.

Bit timing comes from a separate, slower transmit clock. The block resynchronises this clock into the system clock domain and counts its falling edges. The mode byte picks how many such edges make one bit, the character length and the stop length. Frames leave on `txd` least significant bit first. Each frame has a low start bit and one or more high stop bits, and the line rests high between frames. A clear-to-send input gates the start of each frame. Two modem-control outputs follow command bits.

A setup sequence of three zero writes to the control port followed by the soft-reset command always leaves the block waiting for a mode byte, whatever state it was in before. Software therefore has a dependable way to take control of the block.

Top module: `sertx_port`

## Requirements
- R1: After reset the block waits for a mode byte, `txd` is 1, `line_empty` is 1, `hold_free` is 0, and `dtr_n` and `rts_n` are both 1. The first control write (`addr_sel`=1) after reset is taken as the mode byte.
- R2: A write with `addr_sel`=0 loads the transmit holding register. With `addr_sel`=1, `rdata` shows the status byte: bit 0 is `hold_free`, bit 2 is `line_empty`, and all other bits are 0. With `addr_sel`=0, `rdata` is 0x00.
- R3: A command byte with bit 6 set is a soft reset. It stops any frame, empties the holding register, clears all command state and makes the next control write a mode byte. Three writes of 0x00 followed by 0x40 leave the block waiting for a mode byte from any state.
- R4: Mode bits 1:0 select the bit time as a number of transmit-clock falling edges: 01 gives 1, 10 gives 16, 11 gives 64, and 00 is treated as 1. For example, 0x4E on a 57.6 kHz transmit clock gives 3600 bit/s.
- R5: Mode bits 3:2 select the character length as 5 + value bits (00 gives 5, 11 gives 8). The data bits are sent least significant bit first, after one low start bit.
- R6: Mode bits 7:6 select the stop length: 00 and 01 give one bit time, 10 gives one and a half (factor + factor/2 edges), and 11 gives two. A byte waiting in the holding register starts on the edge that ends the stop bits.
- R7: Mode bits 5:4 (parity request) and command bits 2 and 4 have no effect on frame content or timing.
- R8: Command bit 0 enables the transmitter. Command bit 1 drives `dtr_n` low and command bit 5 drives `rts_n` low; each output is high when its bit is 0.
- R9: A frame starts only on a transmit-clock falling edge, with the holding register full, the transmitter enabled and `cts_n` low. Raising `cts_n` during a frame lets that frame finish.
- R10: `hold_free` is 1 exactly when the holding register is empty, the transmitter is enabled and `cts_n` is low. It drops in the cycle after a data write and rises when the byte moves into the shifter.
- R11: `line_empty` is 1 only when both the holding register and the shifter are empty. While it is 1, `txd` is 1.
- R12: A data write while the holding register is already full replaces the waiting byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select for a bus write |
| wr | input | 1 | Single-cycle write strobe |
| addr_sel | input | 1 | 0 selects the data port, 1 selects the control/status port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Status byte when `addr_sel`=1, otherwise 0x00 |
| txc | input | 1 | Transmit clock, asynchronous and slower than `clk` |
| cts_n | input | 1 | Clear to send, active low, synchronous to `clk` |
| txd | output | 1 | Serial output, idle high |
| hold_free | output | 1 | Holding register may take a byte |
| line_empty | output | 1 | Holding register and shifter both empty |
| dtr_n | output | 1 | Data terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |

## Verification
Some properties are checked on every cycle:
- a data write always clears `hold_free` in the next cycle;
- `txd` never moves away from idle unless a resynchronised transmit-clock edge came first;
- the holding register empties only when sending is permitted or a soft reset occurs;
- `txd` is high whenever `line_empty` is set;
- the modem-control outputs track each accepted command.

Other properties can only be shown by the bench's scenarios:
- the mode/command interpretation after the three-zeros-plus-reset setup from different prior states;
- exact bit times and start-to-start spacing for each factor and stop length;
- the character contents;
- overwrite of a waiting byte;
- behaviour when clear-to-send is withheld or removed during a frame.

// File: rtl/sertx_pkg.sv
// Package: shared phase type and decode helpers for the serial transmitter.
// Assumes mode fields are stored raw and decoded where they are used.
package sertx_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } tx_phase_e;

    // Stored mode fields (parity request is not kept).
    typedef struct packed {
        logic [1:0] stop_code;
        logic [1:0] len_code;
        logic [1:0] rate_code;
    } mode_fields_t;

    // Bit time in transmit-clock edges.
    function automatic logic [7:0] rate_edges(input logic [1:0] code);
        case (code)
            2'b10:   rate_edges = 8'd16;
            2'b11:   rate_edges = 8'd64;
            default: rate_edges = 8'd1;
        endcase
    endfunction

    // Stop length in transmit-clock edges.
    function automatic logic [7:0] stop_edges(input logic [1:0] code, input logic [7:0] bit_len);
        case (code)
            2'b11:   stop_edges = bit_len << 1;
            2'b10:   stop_edges = bit_len + (bit_len >> 1);
            default: stop_edges = bit_len;
        endcase
    endfunction

    // Character length in bits.
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        char_bits = 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/sertx_tick.sv
// Module: turns the asynchronous transmit clock into one-cycle ticks.
// Assumes txc is at most a quarter of clk. It resynchronises txc through
// SYNC_STAGES flops and flags each falling edge.
module sertx_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic txc,
    output logic tick
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;

    generate
        for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the raw transmit clock.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= txc;
                end
            end else begin : g_next
                // Pass the sample down the synchroniser chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign tick = chain_q[CHAIN_W-1] & ~chain_q[CHAIN_W-2];

    // R4: a falling edge is flagged for one cycle only.
    a_r4_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sertx_ctrl.sv
// Module: control-port decoder. It holds the mode fields and command state.
// Assumes wr_ctrl is a single-cycle strobe. While mode_pending is set, the
// next control write is taken as the mode byte; after that, writes are commands.
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic [BUS_W-1:0] wdata,
    output mode_fields_t     mode,
    output logic             tx_on,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             soft_rst
);
    localparam int B_TXEN  = 0;
    localparam int B_DTR   = 1;
    localparam int B_RXEN  = 2;
    localparam int B_RTS   = 5;
    localparam int B_RESET = 6;

    logic         mode_pending_q;
    mode_fields_t mode_q;
    logic         tx_on_q, dtr_on_q, rts_on_q, rx_en_q;
    logic         unused_bits;

    assign soft_rst = wr_ctrl && !mode_pending_q && wdata[B_RESET];

    // Interpret each control write as a mode or a command byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_pending_q <= 1'b1;
            mode_q         <= '0;
            tx_on_q        <= 1'b0;
            dtr_on_q       <= 1'b0;
            rts_on_q       <= 1'b0;
            rx_en_q        <= 1'b0;
        end else if (wr_ctrl) begin
            if (mode_pending_q) begin
                mode_q.stop_code <= wdata[7:6];
                mode_q.len_code  <= wdata[3:2];
                mode_q.rate_code <= wdata[1:0];
                mode_pending_q   <= 1'b0;
            end else if (wdata[B_RESET]) begin
                mode_pending_q <= 1'b1;
                tx_on_q        <= 1'b0;
                dtr_on_q       <= 1'b0;
                rts_on_q       <= 1'b0;
                rx_en_q        <= 1'b0;
            end else begin
                tx_on_q  <= wdata[B_TXEN];
                dtr_on_q <= wdata[B_DTR];
                rx_en_q  <= wdata[B_RXEN];
                rts_on_q <= wdata[B_RTS];
            end
        end
    end

    assign mode        = mode_q;
    assign tx_on       = tx_on_q;
    assign dtr_n       = !dtr_on_q;
    assign rts_n       = !rts_on_q;
    assign unused_bits = wdata[4] ^ rx_en_q;

    // R1: a mode write ends the wait for a mode byte.
    a_r1_mode_once: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && mode_pending_q) |=> !mode_pending_q);

    // R3: a reset command returns the block to waiting for a mode byte.
    a_r3_reset_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (mode_pending_q && !tx_on && dtr_n && rts_n));

    // R8: modem outputs follow an accepted command.
    a_r8_modem_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !mode_pending_q && !wdata[B_RESET]) |=>
            (dtr_n == !$past(wdata[B_DTR]) && rts_n == !$past(wdata[B_RTS])));

endmodule

// File: rtl/sertx_shift.sv
// Module: holding register, frame shifter and bit timing.
// Assumes tick marks one transmit-clock edge and cts_n is synchronous to clk.
// A byte moves from the holding register into the shifter only on a tick.
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             soft_rst,
    input  logic             wr_data,
    input  logic [BUS_W-1:0] wdata,
    input  logic             tx_on,
    input  logic             cts_n,
    input  mode_fields_t     mode,
    output logic             txd,
    output logic             hold_free,
    output logic             line_empty
);
    localparam int BITS_W = $clog2(BUS_W + 1);

    logic [BUS_W-1:0]  hold_q, shf_q;
    logic              hold_full_q;
    tx_phase_e         phase_q;
    logic [CNT_W-1:0]  cnt_q, bit_len, stop_len;
    logic [BITS_W-1:0] bits_left_q;
    logic [3:0]        nbits;
    logic              can_start, stop_end, take;

    assign bit_len   = CNT_W'(rate_edges(mode.rate_code));
    assign stop_len  = CNT_W'(stop_edges(mode.stop_code, rate_edges(mode.rate_code)));
    assign nbits     = char_bits(mode.len_code);
    assign can_start = hold_full_q && tx_on && !cts_n;
    assign stop_end  = (phase_q == PH_STOP) && (cnt_q == stop_len - 1'b1);
    assign take      = tick && can_start && ((phase_q == PH_IDLE) || stop_end);

    // Holding register: filled by data writes, emptied by a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
        end else if (soft_rst) begin
            hold_full_q <= 1'b0;
        end else if (wr_data) begin
            hold_q      <= wdata;
            hold_full_q <= 1'b1;
        end else if (take) begin
            hold_full_q <= 1'b0;
        end
    end

    // Frame engine: steps start, data and stop segments on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            phase_q     <= PH_IDLE;
            cnt_q       <= '0;
            shf_q       <= '0;
            bits_left_q <= '0;
        end else if (take) begin
            phase_q     <= PH_START;
            cnt_q       <= '0;
            shf_q       <= hold_q;
            bits_left_q <= BITS_W'(nbits);
        end else if (tick) begin
            case (phase_q)
                PH_START: begin
                    if (cnt_q == bit_len - 1'b1) begin
                        phase_q <= PH_DATA;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_DATA: begin
                    if (cnt_q == bit_len - 1'b1) begin
                        cnt_q       <= '0;
                        shf_q       <= shf_q >> 1;
                        bits_left_q <= bits_left_q - 1'b1;
                        if (bits_left_q == BITS_W'(1)) phase_q <= PH_STOP;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_STOP: begin
                    if (stop_end) begin
                        phase_q <= PH_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Line level from the current segment.
    always_comb begin
        case (phase_q)
            PH_START: txd = 1'b0;
            PH_DATA:  txd = shf_q[0];
            default:  txd = 1'b1;
        endcase
    end

    assign hold_free  = !hold_full_q && tx_on && !cts_n;
    assign line_empty = !hold_full_q && (phase_q == PH_IDLE);

    // R10: a data write removes the ready indication next cycle.
    a_r10_write_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data |=> !hold_free);

    // R11: an empty transmitter keeps the line idle high.
    a_r11_empty_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        line_empty |-> txd);

    // R9: the line level moves only after a transmit-clock edge or a soft reset.
    a_r9_edge_paced: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(txd) |-> ($past(tick) || $past(soft_rst)));

    // R9: the holding register empties only when sending is permitted.
    a_r9_gated_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_full_q) && !$past(soft_rst)) |-> $past(tx_on && !cts_n && tick));

endmodule

// File: rtl/sertx_port.sv
// Module: top of the programmable asynchronous serial transmitter.
// Assumes single-cycle write strobes on clk. It decodes the port select and
// joins the tick generator, the control decoder and the frame engine.
module sertx_port
    import sertx_pkg::*;
#(
    parameter int BUS_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             wr,
    input  logic             addr_sel,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             txc,
    input  logic             cts_n,
    output logic             txd,
    output logic             hold_free,
    output logic             line_empty,
    output logic             dtr_n,
    output logic             rts_n
);
    localparam int ST_READY = 0;
    localparam int ST_EMPTY = 2;

    logic         tick, wr_ctrl, wr_data, tx_on, soft_rst;
    mode_fields_t mode;
    logic [BUS_W-1:0] status;

    assign wr_ctrl = cs && wr && addr_sel;
    assign wr_data = cs && wr && !addr_sel;

    sertx_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .txc(txc), .tick(tick)
    );

    sertx_ctrl #(.BUS_W(BUS_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(wdata),
        .mode(mode), .tx_on(tx_on), .dtr_n(dtr_n), .rts_n(rts_n),
        .soft_rst(soft_rst)
    );

    sertx_shift #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .tick(tick), .soft_rst(soft_rst),
        .wr_data(wr_data), .wdata(wdata), .tx_on(tx_on), .cts_n(cts_n),
        .mode(mode), .txd(txd), .hold_free(hold_free), .line_empty(line_empty)
    );

    // Status byte assembly.
    always_comb begin
        status           = '0;
        status[ST_READY] = hold_free;
        status[ST_EMPTY] = line_empty;
    end

    assign rdata = addr_sel ? status : '0;

endmodule

// File: tb/sertx_port_tb.sv
`timescale 1ns/1ps
module sertx_port_tb;
    localparam int TXC_P = 4;   // transmit-clock period in clk cycles

    logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, wr = 1'b0, addr_sel = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic txc = 1'b0, cts_n = 1'b0;
    logic txd, hold_free, line_empty, dtr_n, rts_n;
    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;

    sertx_port u_dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .addr_sel(addr_sel),
        .wdata(wdata), .rdata(rdata), .txc(txc), .cts_n(cts_n), .txd(txd),
        .hold_free(hold_free), .line_empty(line_empty), .dtr_n(dtr_n), .rts_n(rts_n)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    initial forever begin
        repeat (TXC_P/2) @(posedge clk);
        txc = ~txc;
    end

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_port(input logic sel, input logic [7:0] val);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr_sel = sel; wdata = val;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    function automatic int fac_of(input logic [7:0] m);
        case (m[1:0]) 2'b10: return 16; 2'b11: return 64; default: return 1; endcase
    endfunction

    function automatic int stop_of(input logic [7:0] m);
        int f = fac_of(m);
        case (m[7:6]) 2'b11: return 2*f; 2'b10: return f + f/2; default: return f; endcase
    endfunction

    function automatic logic [7:0] st_exp(input logic rdy, input logic emp);
        return {5'b0, emp, 1'b0, rdy};
    endfunction

    // Waits for a start bit, then samples each bit at its middle.
    task automatic recv(input int fac, input int nb, output int val, output int t0);
        int waited = 0;
        val = 0; t0 = 0;
        while (txd !== 1'b0 && waited < 40000) begin @(negedge clk); waited++; end
        if (waited >= 40000) begin val = -1; return; end
        t0 = cyc;
        repeat (fac*TXC_P/2) @(negedge clk);
        chk("R5 start bit", int'(txd), 0);
        for (int i = 0; i < nb; i++) begin
            repeat (fac*TXC_P) @(negedge clk);
            val = val | (int'(txd) << i);
        end
        repeat (fac*TXC_P) @(negedge clk);
        chk("R6 stop bit", int'(txd), 1);
    endtask

    task automatic robust_setup(input logic [7:0] mode, input logic [7:0] cmd);
        wr_port(1, 8'h00); wr_port(1, 8'h00); wr_port(1, 8'h00);
        wr_port(1, 8'h40);
        wr_port(1, mode);
        wr_port(1, cmd);
    endtask

    task automatic wait_empty();
        int n = 0;
        while (!line_empty && n < 40000) begin @(negedge clk); n++; end
    endtask

    // Two back-to-back frames after the setup sequence; checks data and spacing.
    task automatic b2b(input logic [7:0] mode, input logic [7:0] cmd, input logic [7:0] a, input logic [7:0] b);
        int fac, nb, v1, v2, t1, t2, n;
        logic [7:0] msk;
        fac = fac_of(mode); nb = 5 + int'(mode[3:2]);
        msk = 8'(((1 << nb) - 1));
        robust_setup(mode, cmd);
        chk("R8 dtr_n", int'(dtr_n), int'(!cmd[1]));
        chk("R8 rts_n", int'(rts_n), int'(!cmd[5]));
        fork
            begin recv(fac, nb, v1, t1); recv(fac, nb, v2, t2); end
            begin
                wr_port(0, a);
                n = 0;
                while (!hold_free && n < 1000) begin @(negedge clk); n++; end
                wr_port(0, b);
            end
        join
        chk("R5 R3 first char", v1, int'(a & msk));
        chk("R5 R7 second char", v2, int'(b & msk));
        chk("R4 R6 R7 start spacing", t2 - t1, (1+nb)*fac*TXC_P + stop_of(mode)*TXC_P);
        wait_empty();
        chk("R11 empty after frames", int'(line_empty), 1);
    endtask

    initial begin
        repeat (250000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int v, t, n;
        logic [7:0] md, cm, a, b;
        void'($urandom(32'd7331));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", int'(txd), 1);
        chk("R1 line_empty", int'(line_empty), 1);
        chk("R1 hold_free", int'(hold_free), 0);
        chk("R1 dtr_n", int'(dtr_n), 1);
        chk("R1 rts_n", int'(rts_n), 1);
        addr_sel = 1'b1; #1;
        chk("R2 status after reset", int'(rdata), int'(st_exp(0, 1)));
        addr_sel = 1'b0; #1;
        chk("R2 data port read", int'(rdata), 0);

        // R1: first control write is the mode; 0x4E then 0x37
        wr_port(1, 8'h4E);
        wr_port(1, 8'h37);
        chk("R8 dtr on", int'(dtr_n), 0);
        chk("R8 rts on", int'(rts_n), 0);
        chk("R10 ready after enable", int'(hold_free), 1);
        addr_sel = 1'b1; #1;
        chk("R2 status ready", int'(rdata), int'(st_exp(1, 1)));
        fork
            recv(16, 8, v, t);
            wr_port(0, 8'h41);
        join
        chk("R1 R4 x16 char", v, 8'h41);
        wait_empty();

        // R10/R11: ready falls on write, rises at transfer
        wr_port(0, 8'hC3);
        chk("R10 ready low after write", int'(hold_free), 0);
        chk("R11 not empty with byte held", int'(line_empty), 0);
        n = 0;
        while (txd !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
        chk("R10 ready back at transfer", int'(hold_free), 1);
        chk("R11 busy during frame", int'(line_empty), 0);
        wait_empty();
        chk("R11 idle line", int'(txd), 1);

        // R9: cts withheld holds the byte
        cts_n = 1'b1;
        wr_port(0, 8'h5A);
        n = 0;
        for (int i = 0; i < 40*TXC_P; i++) begin @(negedge clk); if (txd !== 1'b1) n++; end
        chk("R9 no frame without cts", n, 0);
        chk("R9 byte still held", int'(line_empty), 0);
        chk("R10 not ready without cts", int'(hold_free), 0);
        // R12: overwrite of the waiting byte
        wr_port(0, 8'h96);
        fork
            recv(16, 8, v, t);
            begin repeat (3) @(negedge clk); cts_n = 1'b0; end
        join
        chk("R12 overwritten byte sent", v, 8'h96);
        wait_empty();
        chk("R12 no second frame", int'(line_empty), 1);

        // R9: cts removed mid-frame lets the frame finish
        fork
            recv(16, 8, v, t);
            begin
                wr_port(0, 8'h3C);
                n = 0;
                while (txd !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
                repeat (20) @(negedge clk);
                cts_n = 1'b1;
            end
        join
        chk("R9 frame completes after cts drop", v, 8'h3C);
        cts_n = 1'b0;
        wait_empty();

        // R8/R9: transmitter disabled holds the byte
        wr_port(1, 8'h22);
        wr_port(0, 8'h71);
        n = 0;
        for (int i = 0; i < 40*TXC_P; i++) begin @(negedge clk); if (txd !== 1'b1) n++; end
        chk("R9 no frame when disabled", n, 0);
        fork
            recv(16, 8, v, t);
            wr_port(1, 8'h23);
        join
        chk("R8 enable releases byte", v, 8'h71);
        wait_empty();

        // R3: soft reset during a frame
        wr_port(0, 8'h5A);
        n = 0;
        while (txd !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
        repeat (20) @(negedge clk);
        wr_port(1, 8'h40);
        chk("R3 line idle after reset", int'(txd), 1);
        chk("R3 empty after reset", int'(line_empty), 1);
        chk("R3 dtr released", int'(dtr_n), 1);
        chk("R3 not ready after reset", int'(hold_free), 0);
        wr_port(1, 8'h4D);
        wr_port(1, 8'h21);
        chk("R3 mode then command rts", int'(rts_n), 0);
        chk("R3 mode then command dtr", int'(dtr_n), 1);
        fork
            recv(1, 8, v, t);
            wr_port(0, 8'hA5);
        join
        chk("R4 x1 char", v, 8'hA5);
        wait_empty();

        // Directed stop lengths and parity request
        b2b(8'h8E, 8'h37, 8'h12, 8'hE7);   // 1.5 stop, x16
        b2b(8'hCD, 8'h03, 8'h81, 8'h7E);   // 2 stop, x1
        b2b(8'h9E, 8'h35, 8'h55, 8'hAA);   // parity request set (R7)
        b2b(8'h43, 8'h21, 8'h1F, 8'h10);   // 5 bits, x64

        // Random modes from random prior states (R3 robust setup)
        for (int it = 0; it < 12; it++) begin
            int rc, pre;
            rc = $urandom_range(1, 3);
            if (rc == 3 && (it % 4) != 0) rc = 2;
            md = {2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                  2'($urandom_range(0, 3)), 2'(rc)};
            cm = 8'h01 | (8'($urandom_range(0, 1)) << 1) | (8'($urandom_range(0, 1)) << 2)
                       | (8'($urandom_range(0, 1)) << 4) | (8'($urandom_range(0, 1)) << 5);
            pre = $urandom_range(0, 2);
            if (pre == 0) wr_port(1, 8'h40);
            else if (pre == 2) wr_port(1, 8'($urandom_range(0, 255)) & 8'hBE);
            a = 8'($urandom_range(0, 255));
            b = 8'($urandom_range(0, 255));
            b2b(md, cm, a, b);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule